// File: doc/BRIEF.md
# Multichannel Counter-Based Debounce Filter

This block cleans contact bounce and short glitches off a bank of digital inputs that are already sampled on the block clock. Every lane keeps a filtered output bit and a run counter of its own. On each clock edge a lane compares the new sample against its present filtered output. While the two disagree the counter advances. Once the counter is strictly greater than a threshold that is supplied at run time, the lane adopts the sampled value and the counter returns to zero. A sample that agrees with the output clears the counter at once, so a bounce that ends early leaves no trace.

The threshold is a single unsigned word shared by all lanes and read on every cycle. The block is placed directly behind the input synchronizers and ahead of edge or pulse counting logic. A lane cannot see a pulse that starts and ends between two clock edges.

Top module: `dbn_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives every output bit to 0 and clears every counter. After reset ends, a lane needs a complete disagreement run before its output can change.
- R2: Each lane compares its sample with its own filtered output. A sample equal to the output clears that lane's counter, and the output keeps its value at that edge.
- R3: Let T be the threshold. If the sample differs from the output for T+2 consecutive edges, the output takes the sampled value at the (T+2)th edge. It is visible right after that edge.
- R4: A disagreement run of T+1 edges or fewer, followed by an agreeing sample, never changes the output. The next run starts counting from zero.
- R5: With T = 0, a single-edge pulse is rejected and a pulse held for two edges is accepted.
- R6: Lanes are independent. With the default of 8 lanes, different patterns on different lanes in the same cycles each give their own result.
- R7: The threshold is read on every edge. Lowering it below a lane's running count makes the lane accept the new value at the next edge.
- R8: The counter saturates at 2^16-1 and does not wrap. With the threshold at 16'hFFFF, outputs never change however long the disagreement lasts. Lowering the threshold afterwards releases the change on the next edge.
- R9: After a change is accepted the counter is zero, so a later opposite change again needs a full T+2 edge run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | LANES (8) | Sampled raw inputs, one bit per lane |
| thresh | input | THR_W (16) | Unsigned filter threshold shared by all lanes |
| filt_out | output | LANES (8) | Registered filtered outputs |

## Verification
Counting and threshold comparison meet in a single edge when the threshold is lowered while a lane is mid-run. The same edge then both advances the count and must accept the change. The bench sets up this case by raising the threshold, holding a disagreement for five edges, and then dropping the threshold to 2. The scoreboard expects the output to flip at that very edge. The same collision is set up at the saturation limit: after more than 65 535 edges of disagreement against an all-ones threshold, the threshold falls to zero and the release is judged on the following edge.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    // Default geometry of the filter bank
    localparam int unsigned DBN_LANES_DEF = 8;
    localparam int unsigned DBN_THR_W_DEF = 16;

    // What a lane decided on the current edge
    typedef enum logic [1:0] {
        LANE_IDLE   = 2'd0,  // sample agrees with output, counter cleared
        LANE_COUNT  = 2'd1,  // disagreement, counter advances
        LANE_ACCEPT = 2'd2   // counter above threshold, output takes sample
    } lane_act_e;

endpackage

// File: rtl/dbn_sat_inc.sv
module dbn_sat_inc #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] inc_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Advance by one, hold at all-ones instead of wrapping
    always_comb begin
        if (val_i == TOP) begin
            inc_o = TOP;
        end else begin
            inc_o = val_i + {{(W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/dbn_cmp_gt.sv
module dbn_cmp_gt #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    output logic         gt_o
);
    // Strict unsigned greater-than
    always_comb begin
        gt_o = (lhs_i > rhs_i);
    end
endmodule

// File: rtl/dbn_lane.sv
module dbn_lane
    import dbn_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             filt_o
);
    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] run;
    } lane_st_t;

    lane_st_t  st_d, st_q;
    lane_act_e act_d;
    logic [CNT_W-1:0] run_inc;
    logic             over_limit;
    logic             differs;

    dbn_sat_inc #(.W(CNT_W)) u_inc (
        .val_i (st_q.run),
        .inc_o (run_inc)
    );

    dbn_cmp_gt #(.W(CNT_W)) u_gt (
        .lhs_i (st_q.run),
        .rhs_i (limit_i),
        .gt_o  (over_limit)
    );

    always_comb begin
        differs = (sample_i != st_q.level);
    end

    // Next-state computation
    always_comb begin
        st_d  = st_q;
        act_d = LANE_IDLE;
        if (differs) begin
            if (over_limit) begin
                act_d = LANE_ACCEPT;
            end else begin
                act_d = LANE_COUNT;
            end
        end
        unique case (act_d)
            LANE_ACCEPT: begin
                st_d.level = sample_i;
                st_d.run   = '0;
            end
            LANE_COUNT: begin
                st_d.run   = run_inc;
            end
            default: begin
                st_d.run   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.level;
endmodule

// File: rtl/dbn_bank.sv
module dbn_bank
    import dbn_pkg::*;
#(
    parameter int unsigned LANES = DBN_LANES_DEF,
    parameter int unsigned THR_W = DBN_THR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] raw_in,
    input  logic [THR_W-1:0] thresh,
    output logic [LANES-1:0] filt_out
);
    // Counter width matches the threshold so all-ones cannot be exceeded
    localparam int unsigned CNT_W = THR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dbn_lane #(.CNT_W(CNT_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .sample_i (raw_in[g]),
            .limit_i  (thresh),
            .filt_o   (filt_out[g])
        );
    end
endmodule

// File: rtl/dbn_bank_chk.sv
module dbn_bank_chk #(
    parameter int unsigned LANES = 8,
    parameter int unsigned THR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] raw_in,
    input logic [THR_W-1:0] thresh,
    input logic [LANES-1:0] filt_out
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            reset_clear_chk: assert (filt_out == '0);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        // R2
        agree_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (raw_in[g] == filt_out[g]) |=> $stable(filt_out[g]));

        // R3
        takes_sample_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(filt_out[g]) |-> (filt_out[g] == $past(raw_in[g])));

        // R5
        two_edge_min_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(filt_out[g]) |-> ($past(raw_in[g], 2) != $past(filt_out[g], 2)));

        // R8
        freeze_at_max_chk: assert property (@(posedge clk) disable iff (rst)
            (thresh == {THR_W{1'b1}}) |=> $stable(filt_out[g]));
    end
endmodule

bind dbn_bank dbn_bank_chk #(.LANES(LANES), .THR_W(THR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .raw_in   (raw_in),
    .thresh   (thresh),
    .filt_out (filt_out)
);

// File: tb/dbn_bank_test.sv
module dbn_bank_test;
    localparam int LANES = 8;
    localparam int THR_W = 16;
    localparam int SAT   = 65535;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] raw = '0;
    logic [THR_W-1:0] thr = '0;
    logic [LANES-1:0] filt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [LANES-1:0] exp;
        string            tag;
    } sb_item_t;

    sb_item_t sbq[$];

    // Expected-state model from the requirements
    logic [LANES-1:0] m_out = '0;
    int               m_run[LANES];

    always #2.5 clk = ~clk;  // 200 MHz

    dbn_bank #(.LANES(LANES), .THR_W(THR_W)) uut (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (raw),
        .thresh   (thr),
        .filt_out (filt)
    );

    task automatic push(input logic [LANES-1:0] e, input string tag);
        sb_item_t it;
        it.exp = e;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic do_reset(input int n, input logic [LANES-1:0] r);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rst = 1'b1;
            raw = r;
            m_out = '0;
            for (int j = 0; j < LANES; j++) m_run[j] = 0;
            push('0, "R1");
        end
    endtask

    task automatic step(input logic [LANES-1:0] r, input logic [THR_W-1:0] t, input string tag);
        @(negedge clk);
        rst = 1'b0;
        raw = r;
        thr = t;
        for (int j = 0; j < LANES; j++) begin
            if (r[j] != m_out[j]) begin
                if (m_run[j] > int'(t)) begin
                    m_out[j] = r[j];
                    m_run[j] = 0;
                end else if (m_run[j] < SAT) begin
                    m_run[j] = m_run[j] + 1;
                end
            end else begin
                m_run[j] = 0;
            end
        end
        push(m_out, tag);
    endtask

    task automatic hold(input logic [LANES-1:0] r, input logic [THR_W-1:0] t, input int n, input string tag);
        for (int k = 0; k < n; k++) step(r, t, tag);
    endtask

    // Monitor: compare output just after each edge against the queue
    initial begin
        sb_item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                checks++;
                if (filt !== it.exp) begin
                    errors++;
                    $display("FAIL %s: filt_out=%b expected=%b at %0t", it.tag, filt, it.exp, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [LANES-1:0] r;
        for (int j = 0; j < LANES; j++) m_run[j] = 0;

        // R1: reset state
        do_reset(3, 8'hA5);

        // R3 R4 R6: threshold 2, lane j gets a pulse of j+1 edges
        for (int k = 0; k < 30; k++) begin
            for (int j = 0; j < LANES; j++) r[j] = (k >= 2) && (k < 3 + j);
            step(r, 16'd2, "R3 R4 R6 pulse widths");
        end
        hold('0, 16'd2, 8, "R3 R4 settle");

        // R5: threshold 0, odd lanes two-edge pulse, even lanes one-edge
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < LANES; j++) r[j] = (k == 2) || ((j % 2 == 1) && (k == 3));
            step(r, 16'd0, "R5 minimum width");
        end
        hold('0, 16'd0, 4, "R5 settle");

        // R2 R4: threshold 3, runs of 3 broken by agreeing samples
        for (int k = 0; k < 16; k++) begin
            r = (k % 4 == 3) ? 8'h00 : 8'hFF;
            step(r, 16'd3, "R2 R4 counter restart");
        end

        // R9: accept, then short opposite run rejected, long run accepted
        hold(8'hFF, 16'd3, 8, "R9 accept high");
        hold(8'h00, 16'd3, 4, "R9 short low run");
        hold(8'hFF, 16'd3, 4, "R9 back high");
        hold(8'h00, 16'd3, 8, "R9 full low run");

        // R7: threshold lowered mid-run
        hold(8'h3C, 16'd10, 5, "R7 count under high limit");
        hold(8'h3C, 16'd2, 3, "R7 lowered limit");
        hold(8'h00, 16'd2, 8, "R7 settle");

        // R8: saturation and freeze at all-ones threshold, then release
        hold(8'hFF, 16'hFFFF, 70000, "R8 frozen");
        step(8'hFF, 16'd0, "R8 release");
        hold(8'hFF, 16'd0, 2, "R8 after release");

        // R1: reset while outputs are high, then a full run needed again
        do_reset(2, 8'hFF);
        hold(8'hFF, 16'd4, 8, "R1 after reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule